// File: doc/BRIEF.md
# Delayed Write Completion Tracker

This block keeps the bookkeeping for delayed write transactions in a bus bridge. An initiator's write attempt is compared with a small table of stored transactions. If nothing matches and a slot is free, the attempt is stored. If it matches a transaction whose data has not yet been delivered, it is answered with retry. If it matches a transaction that has completed on the target side, it is answered with completion and the slot is released. The target side sees the oldest undelivered transaction on a forward port and acknowledges each delivery with a one-cycle strobe.

Completed transactions form a queue that is oldest first. Only the completion at the head of that queue is aged. A discard timer is loaded from a programmable reload value when a completion reaches the head. If the initiator does not return before the timer runs out, the completion is dropped and an enable-gated error pulse is produced. Retry and completion decisions, allocation, matching and aging all live here. Bus signalling and data movement are left to the neighbouring logic.

Top module: `dwt_tracker`

## Requirements
- R1: `rsp_o` reports the answer to an attempt sampled at a clock edge during the cycle that follows that edge. The encoding is 0 = no attempt, 1 = retry, 2 = completion. In all other cycles `rsp_o` is 0.
- R2: An attempt that matches a stored transaction whose data is not yet delivered is answered with retry (1) and allocates no slot.
- R3: An attempt that matches nothing is stored in a free slot and is answered with retry (1). The forward port presents the oldest undelivered stored transaction, in allocation order. Each `fwd_done_i` strobe marks that transaction as delivered.
- R4: A match needs address, command, byte enables and data to be equal. An attempt that differs in any one of these fields is treated as a separate transaction.
- R5: When every slot is occupied, a non-matching attempt is answered with retry (1) and is not stored.
- R6: An attempt that matches a delivered transaction is answered with completion (2), and its slot becomes free.
- R7: Suppose a completion becomes head of the completion queue at edge E, with reload value R. It can still be claimed by an attempt sampled at any edge up to and including E+R+2. It is discarded at edge E+R+2 if no attempt claims it there. A later identical attempt is then a new transaction.
- R8: `err_o` is high for exactly the one cycle after a discard, and only if `err_en_i` was high in the cycle in which the discard happened.
- R9: Completions are aged oldest first. A younger completion's timer starts only when it becomes head, after the older completion leaves the queue.
- R10: After reset, `rsp_o` is 0, `fwd_valid_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| att_valid_i | input | 1 | Initiator write attempt present this cycle |
| att_addr_i | input | AW | Attempt address |
| att_cmd_i | input | CW | Attempt command code |
| att_be_i | input | BW | Attempt byte enables |
| att_data_i | input | DW | Attempt write data |
| rsp_o | output | 2 | Registered answer: 0 none, 1 retry, 2 completion |
| fwd_valid_o | output | 1 | An undelivered transaction is presented |
| fwd_addr_o | output | AW | Address of oldest undelivered transaction |
| fwd_cmd_o | output | CW | Its command code |
| fwd_be_o | output | BW | Its byte enables |
| fwd_data_o | output | DW | Its data |
| fwd_done_i | input | 1 | Target delivered the presented transaction |
| reload_i | input | TW | Discard timer starting value |
| err_en_i | input | 1 | Enables the discard error pulse |
| err_o | output | 1 | One-cycle pulse per discarded completion |

## Verification
Every answer on `rsp_o` and every change of the forward port is due one cycle after the edge that sampled the stimulus. The bench drives each input on a falling edge and checks the results on the next falling edge, so each check lands exactly one register stage after its cause. Aging results are counted from the delivery edge E. With a small reload value, the bench presents the claiming attempt at edge E+R+2 in one test and one edge later in another. It looks at `err_o` after each idle cycle in between, which pins the discard and the error pulse to their exact cycle.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_RETRY = 2'd1,
    RSP_DONE  = 2'd2
  } rsp_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } slot_st_e;

endpackage

// File: rtl/dwt_age_order.sv
// Age matrix over the slots: picks the oldest slot of two masks.
module dwt_age_order #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_oh_i,
  input  logic [N-1:0] wait_m_i,
  input  logic [N-1:0] done_m_i,
  output logic [N-1:0] oldest_wait_oh_o,
  output logic [N-1:0] oldest_done_oh_o
);

  // older_q[i][j] set: slot i was allocated before slot j
  logic [N-1:0] older_q [N];
  logic [N-1:0] older_d [N];

  always_comb begin
    for (int i = 0; i < N; i++) older_d[i] = older_q[i];
    for (int k = 0; k < N; k++) begin
      if (alloc_oh_i[k]) begin
        for (int j = 0; j < N; j++) begin
          older_d[k][j] = 1'b0;
          if (j != k) older_d[j][k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else if (|alloc_oh_i) begin
      for (int i = 0; i < N; i++) older_q[i] <= older_d[i];
    end
  end

  always_comb begin
    oldest_wait_oh_o = wait_m_i;
    oldest_done_oh_o = done_m_i;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && older_q[j][i]) begin
          if (wait_m_i[j]) oldest_wait_oh_o[i] = 1'b0;
          if (done_m_i[j]) oldest_done_oh_o[i] = 1'b0;
        end
      end
    end
  end

  assert_oldest_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oldest_done_oh_o) && $onehot0(oldest_wait_oh_o));

  assert_oldest_present_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wait_m_i) |-> (|oldest_wait_oh_o));

endmodule

// File: rtl/dwt_entry_match.sv
// Parallel full-key comparison against every occupied slot.
module dwt_entry_match #(
  parameter int unsigned N  = 4,
  parameter int unsigned KW = 72
) (
  input  logic [KW-1:0] key_i,
  input  logic [KW-1:0] slot_key_i [N],
  input  logic [N-1:0]  used_m_i,
  output logic [N-1:0]  hit_oh_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_oh_o[g] = used_m_i[g] && (slot_key_i[g] == key_i);
  end

endmodule

// File: rtl/dwt_discard_timer.sv
// Ages the completion at the head of the queue.
module dwt_discard_timer #(
  parameter int unsigned N  = 4,
  parameter int unsigned TW = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          head_valid_i,
  input  logic [IW-1:0] head_idx_i,
  input  logic [TW-1:0] reload_i,
  output logic          expire_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] head_q, head_d;
  logic          armed_q, armed_d;
  logic          same_head;

  assign same_head = armed_q && head_valid_i && (head_idx_i == head_q);
  assign expire_o  = same_head && (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    head_d  = head_q;
    armed_d = armed_q;
    if (same_head) begin
      if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d   = reload_i;
      head_d  = head_idx_i;
      armed_d = head_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      head_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      head_q  <= head_d;
      armed_q <= armed_d;
    end
  end

  assert_timer_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> (cnt_q == $past(reload_i)));

  assert_expire_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

endmodule

// File: rtl/dwt_tracker.sv
module dwt_tracker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 4,
  parameter int unsigned BW    = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned TW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          att_valid_i,
  input  logic [AW-1:0] att_addr_i,
  input  logic [CW-1:0] att_cmd_i,
  input  logic [BW-1:0] att_be_i,
  input  logic [DW-1:0] att_data_i,
  output logic [1:0]    rsp_o,
  output logic          fwd_valid_o,
  output logic [AW-1:0] fwd_addr_o,
  output logic [CW-1:0] fwd_cmd_o,
  output logic [BW-1:0] fwd_be_o,
  output logic [DW-1:0] fwd_data_o,
  input  logic          fwd_done_i,
  input  logic [TW-1:0] reload_i,
  input  logic          err_en_i,
  output logic          err_o
);
  import dwt_pkg::*;

  localparam int unsigned KW = AW + CW + BW + DW;
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [KW-1:0] key_q [DEPTH];
  slot_st_e      st_q  [DEPTH];
  slot_st_e      st_d  [DEPTH];
  logic [KW-1:0] att_key, fwd_key;

  logic [DEPTH-1:0] wait_m, done_m, used_m, free_m, free_pick;
  logic [DEPTH-1:0] hit_oh, alloc_oh, claim_oh, deliver_oh, discard_oh;
  logic [DEPTH-1:0] oldest_wait_oh, head_oh;
  logic             hit_any, hit_done, expire;
  logic [IW-1:0]    head_idx;
  rsp_e             rsp_q, rsp_d;
  logic             err_q, err_d;

  assign att_key = {att_addr_i, att_cmd_i, att_be_i, att_data_i};

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      wait_m[i] = (st_q[i] == ST_WAIT);
      done_m[i] = (st_q[i] == ST_DONE);
      used_m[i] = (st_q[i] != ST_FREE);
    end
    free_m = ~used_m;
  end

  // lowest-numbered free slot
  always_comb begin
    free_pick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_m[i]) free_pick = DEPTH'(1) << i;
    end
  end

  dwt_entry_match #(.N(DEPTH), .KW(KW)) match_i (
    .key_i      (att_key),
    .slot_key_i (key_q),
    .used_m_i   (used_m),
    .hit_oh_o   (hit_oh)
  );

  assign hit_any  = |hit_oh;
  assign hit_done = |(hit_oh & done_m);

  dwt_age_order #(.N(DEPTH)) order_i (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .alloc_oh_i       (alloc_oh),
    .wait_m_i         (wait_m),
    .done_m_i         (done_m),
    .oldest_wait_oh_o (oldest_wait_oh),
    .oldest_done_oh_o (head_oh)
  );

  always_comb begin
    head_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (head_oh[i]) head_idx = IW'(i);
    end
  end

  dwt_discard_timer #(.N(DEPTH), .TW(TW)) timer_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_valid_i (|head_oh),
    .head_idx_i   (head_idx),
    .reload_i     (reload_i),
    .expire_o     (expire)
  );

  // per-slot events; a claim on the head wins over its expiry
  always_comb begin
    alloc_oh   = (att_valid_i && !hit_any) ? free_pick : '0;
    claim_oh   = att_valid_i ? (hit_oh & done_m) : '0;
    deliver_oh = fwd_done_i ? oldest_wait_oh : '0;
    discard_oh = expire ? (head_oh & ~claim_oh) : '0;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      st_d[i] = st_q[i];
      if (alloc_oh[i])                      st_d[i] = ST_WAIT;
      else if (claim_oh[i] || discard_oh[i]) st_d[i] = ST_FREE;
      else if (deliver_oh[i])               st_d[i] = ST_DONE;
    end
  end

  always_comb begin
    if (!att_valid_i)  rsp_d = RSP_NONE;
    else if (hit_done) rsp_d = RSP_DONE;
    else               rsp_d = RSP_RETRY;
    err_d = (|discard_oh) && err_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_FREE;
      rsp_q <= RSP_NONE;
      err_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= st_d[i];
      rsp_q <= rsp_d;
      err_q <= err_d;
    end
  end

  // key storage: written only on allocation
  for (genvar g = 0; g < DEPTH; g++) begin : g_key
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          key_q[g] <= '0;
      else if (alloc_oh[g]) key_q[g] <= att_key;
    end
  end

  always_comb begin
    fwd_key = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (oldest_wait_oh[i]) fwd_key = key_q[i];
    end
  end

  assign fwd_valid_o = |wait_m;
  assign {fwd_addr_o, fwd_cmd_o, fwd_be_o, fwd_data_o} = fwd_key;
  assign rsp_o = rsp_q;
  assign err_o = err_q;

  assert_hit_no_alloc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_valid_i && hit_any) |=> ($countones(used_m) <= $past($countones(used_m))));

  assert_wait_retry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_valid_i && |(hit_oh & wait_m)) |=> (rsp_o == 2'd1));

  assert_full_retry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_valid_i && !hit_any && free_m == '0) |=>
      (rsp_o == 2'd1 && $countones(used_m) <= $past($countones(used_m))));

  assert_done_rsp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_valid_i && hit_done) |=> (rsp_o == 2'd2));

  assert_err_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_idle_rsp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !att_valid_i |=> (rsp_o == 2'd0));

endmodule

// File: tb/dwt_tracker_tb.sv
module dwt_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        att_valid, fwd_done, err_en;
  logic [31:0] att_addr, att_data;
  logic [3:0]  att_cmd, att_be;
  logic [1:0]  rsp;
  logic        fwd_valid, err;
  logic [31:0] fwd_addr, fwd_data;
  logic [3:0]  fwd_cmd, fwd_be;
  logic [15:0] reload;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dwt_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .att_valid_i(att_valid), .att_addr_i(att_addr), .att_cmd_i(att_cmd),
    .att_be_i(att_be), .att_data_i(att_data),
    .rsp_o(rsp),
    .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr), .fwd_cmd_o(fwd_cmd),
    .fwd_be_o(fwd_be), .fwd_data_o(fwd_data),
    .fwd_done_i(fwd_done), .reload_i(reload), .err_en_i(err_en), .err_o(err)
  );

  localparam int OP_IDLE = 0;
  localparam int OP_ATT  = 1;
  localparam int OP_DLV  = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [1:0]  exp_rsp;
    logic        exp_fv;
    logic [31:0] exp_faddr;
  } vec_t;

  localparam logic [31:0] A1 = 32'h0000_1000;
  localparam logic [31:0] A2 = 32'h0000_2040;

  // covers R1, R2, R3 and R6 with retry=1, completion=2
  localparam vec_t VEC [10] = '{
    '{2'd1, A1, 2'd1, 1'b1, A1},
    '{2'd1, A1, 2'd1, 1'b1, A1},
    '{2'd1, A2, 2'd1, 1'b1, A1},
    '{2'd2, 32'h0, 2'd0, 1'b1, A2},
    '{2'd1, A1, 2'd2, 1'b1, A2},
    '{2'd1, A1, 2'd1, 1'b1, A2},
    '{2'd2, 32'h0, 2'd0, 1'b1, A1},
    '{2'd1, A2, 2'd2, 1'b1, A1},
    '{2'd2, 32'h0, 2'd0, 1'b0, A1},
    '{2'd1, A1, 2'd2, 1'b0, A1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle at a falling edge; results are visible at the next falling edge
  task automatic step(input int op, input logic [31:0] a, input logic [3:0] be);
    att_valid = (op == OP_ATT);
    att_addr  = a;
    att_cmd   = 4'h7;
    att_be    = be;
    att_data  = a ^ 32'h5A5A_0F0F;
    fwd_done  = (op == OP_DLV);
    @(negedge clk);
    att_valid = 1'b0;
    fwd_done  = 1'b0;
  endtask

  task automatic att_exp(input logic [31:0] a, input logic [3:0] be, input logic [1:0] e, input string tag);
    step(OP_ATT, a, be);
    chk(rsp == e, tag, rsp, e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int ecount;
    rst_n = 1'b0; att_valid = 1'b0; fwd_done = 1'b0; err_en = 1'b1;
    att_addr = '0; att_data = '0; att_cmd = '0; att_be = '0; reload = 16'd100;
    repeat (3) @(negedge clk);
    chk(rsp == 2'd0, "R10 rsp after reset", rsp, 0);
    chk(fwd_valid == 1'b0, "R10 fwd_valid after reset", fwd_valid, 0);
    chk(err == 1'b0, "R10 err after reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R3 R6
    for (int i = 0; i < 10; i++) begin
      step(int'(VEC[i].op), VEC[i].addr, 4'hF);
      chk(rsp == VEC[i].exp_rsp, "R1 table rsp", rsp, VEC[i].exp_rsp);
      chk(fwd_valid == VEC[i].exp_fv, "R3 table fwd_valid", fwd_valid, VEC[i].exp_fv);
      if (VEC[i].exp_fv)
        chk(fwd_addr == VEC[i].exp_faddr, "R3 table fwd_addr", fwd_addr, VEC[i].exp_faddr);
    end

    // R4: byte-enable difference makes a separate transaction
    att_exp(32'h3000, 4'hF, 2'd1, "R4 first store");
    att_exp(32'h3000, 4'h3, 2'd1, "R4 differing be retried");
    step(OP_DLV, 0, 0);
    chk(fwd_valid == 1'b1, "R4 second entry exists", fwd_valid, 1);
    chk(fwd_be == 4'h3, "R4 second entry be", fwd_be, 4'h3);
    chk(fwd_data == (32'h3000 ^ 32'h5A5A_0F0F), "R4 stored data", fwd_data, 32'h3000 ^ 32'h5A5A_0F0F);
    att_exp(32'h3000, 4'h3, 2'd1, "R4 undelivered repeat");
    step(OP_DLV, 0, 0);
    chk(fwd_valid == 1'b0, "R4 no third entry", fwd_valid, 0);
    att_exp(32'h3000, 4'hF, 2'd2, "R4 claim first");
    att_exp(32'h3000, 4'h3, 2'd2, "R4 claim second");

    // R5: full table
    for (int i = 0; i < 4; i++) att_exp(32'h4000 + 32'(i) * 32'h10, 4'hF, 2'd1, "R3 fill");
    att_exp(32'h4040, 4'hF, 2'd1, "R5 full retry");
    for (int i = 0; i < 4; i++) begin
      chk(fwd_addr == 32'h4000 + 32'(i) * 32'h10, "R3 delivery order", fwd_addr, 32'h4000 + 32'(i) * 32'h10);
      step(OP_DLV, 0, 0);
    end
    chk(fwd_valid == 1'b0, "R5 overflow attempt not stored", fwd_valid, 0);
    for (int i = 0; i < 4; i++) att_exp(32'h4000 + 32'(i) * 32'h10, 4'hF, 2'd2, "R6 claim");
    chk(fwd_valid == 1'b0, "R6 table empty", fwd_valid, 0);

    // R7: claim at the last allowed edge
    reload = 16'd5;
    att_exp(32'h5000, 4'hF, 2'd1, "R7 store");
    step(OP_DLV, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(OP_IDLE, 0, 0);
      chk(err == 1'b0, "R7 no discard yet", err, 0);
    end
    att_exp(32'h5000, 4'hF, 2'd2, "R7 claim at E+R+2");
    chk(err == 1'b0, "R7 claim beats expiry", err, 0);

    // R7/R8: discard one edge later
    att_exp(32'h5000, 4'hF, 2'd1, "R7 store again");
    step(OP_DLV, 0, 0);
    for (int i = 1; i <= 7; i++) begin
      step(OP_IDLE, 0, 0);
      chk(err == (i == 7), "R8 err timing", err, (i == 7));
    end
    att_exp(32'h5000, 4'hF, 2'd1, "R7 discarded entry is new");
    chk(err == 1'b0, "R8 err one cycle", err, 0);
    step(OP_DLV, 0, 0);
    att_exp(32'h5000, 4'hF, 2'd2, "R7 cleanup");

    // R8: error disabled
    err_en = 1'b0;
    att_exp(32'h6000, 4'hF, 2'd1, "R8 store");
    step(OP_DLV, 0, 0);
    ecount = 0;
    for (int i = 0; i < 9; i++) begin
      step(OP_IDLE, 0, 0);
      if (err) ecount++;
    end
    chk(ecount == 0, "R8 gated err", ecount, 0);
    att_exp(32'h6000, 4'hF, 2'd1, "R8 still discarded");
    step(OP_DLV, 0, 0);
    att_exp(32'h6000, 4'hF, 2'd2, "R8 cleanup");
    err_en = 1'b1;

    // R9: younger completion not aged while older is head
    att_exp(32'h7000, 4'hF, 2'd1, "R9 store older");
    att_exp(32'h7100, 4'hF, 2'd1, "R9 store younger");
    step(OP_DLV, 0, 0);
    step(OP_DLV, 0, 0);
    ecount = 0;
    for (int i = 0; i < 10; i++) begin
      step(OP_IDLE, 0, 0);
      if (err) ecount++;
    end
    chk(ecount == 1, "R9 only older discarded", ecount, 1);
    att_exp(32'h7100, 4'hF, 2'd2, "R9 younger still claimable");
    att_exp(32'h7000, 4'hF, 2'd1, "R9 older was discarded");
    step(OP_DLV, 0, 0);
    att_exp(32'h7000, 4'hF, 2'd2, "R9 cleanup");
    step(OP_IDLE, 0, 0);
    chk(rsp == 2'd0, "R1 idle rsp", rsp, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule